// File: doc/BRIEF.md
# Dual-Converter Conversion Scheduler with Inserted-Group Preemption

This block sequences two converters that run from one clock. In regular mode both converters convert the same regular channel, with the second one's conversion offset from the first's. The offset has a fast setting and a slow setting. A conversion is modelled as a fixed 14-clock window: a short sample phase followed by a convert phase. The block drives a sample strobe, a convert strobe and a channel index to each converter.

An inserted trigger suspends regular work on both converters at once. Both converters then run their own inserted channel lists side by side. When the last inserted conversion finishes, regular work starts again from the beginning of its period on the regular channel. Any regular conversion that was cut short is dropped and reports nothing. A trigger that arrives while an inserted run is in progress is discarded and is not remembered.

Completed conversions feed three sticky event flags: regular done, inserted done and window watchdog. A single interrupt line combines the enabled flags of both converters.

Top module: `conv_pair_sched`

## Requirements
- R1: While reset is held and right after it is released, with `reg_en` and `ins_trig` low, all strobes, `flags` and `irq` are 0.
- R2: Fast mode (`slow_mode`=0), with `reg_en` high. Converter A starts a 14-cycle conversion every 14 cycles. Converter B starts its first conversion 7 cycles after A. Both use `reg_ch`. In each conversion the sample strobe is high for cycles 0..2 and the convert strobe for cycles 3..13.
- R3: Slow mode (`slow_mode`=1). The period is 28 cycles. A converts in period cycles 0..13 and B in cycles 14..27, with the same sample and convert split as in R2.
- R4: When `ins_trig` is high and no inserted run is active, both converters are in inserted entry 0 on the next cycle. This holds in both regular modes and from idle. Entry k uses channel `ins_ch_a[4k+3:4k]` on A and `ins_ch_b[4k+3:4k]` on B. `ins_last`+1 entries run back to back, 14 cycles each.
- R5: `ins_trig` during an inserted run is ignored and is not queued. The run continues through its entries, and regular work follows it.
- R6: After the last inserted conversion, if `reg_en` is high, regular work restarts at period cycle 0. A samples `reg_ch` at once and B follows after the stagger. A regular conversion cut short by preemption never sets the regular-done flag.
- R7: `flags[0]` is set in the cycle after converter B completes a regular conversion.
- R8: `flags[1]` is set in the cycle after the last conversion of an inserted run completes.
- R9: `flags[2]` is set in the cycle after either converter completes a conversion whose `ain` value is below `wd_lo` or above `wd_hi`. Values equal to a threshold do not set it.
- R10: Flags stay set until a cycle with the matching `clr_flag` bit high. A flag that is set and cleared in the same cycle stays set.
- R11: `irq` is high exactly when some bit of `flags & int_en` is 1. The bit order matches `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_en | input | 1 | Run regular follow-up conversions |
| slow_mode | input | 1 | 0: 7-cycle stagger, 1: 14-cycle stagger (change only while idle) |
| reg_ch | input | 4 | Regular channel index |
| ins_trig | input | 1 | Inserted-group trigger |
| ins_last | input | 2 | Number of inserted entries minus one |
| ins_ch_a | input | 16 | Inserted channel list of converter A, 4 bits per entry |
| ins_ch_b | input | 16 | Inserted channel list of converter B, 4 bits per entry |
| ain_a | input | 12 | Modelled result of converter A, taken at the end of a conversion |
| ain_b | input | 12 | Modelled result of converter B, taken at the end of a conversion |
| wd_lo | input | 12 | Watchdog low threshold |
| wd_hi | input | 12 | Watchdog high threshold |
| int_en | input | 3 | Interrupt enables {watchdog, inserted, regular} |
| clr_flag | input | 3 | Per-flag clear strobes |
| smp_a | output | 1 | Converter A sample strobe |
| cnv_a | output | 1 | Converter A convert strobe |
| ch_a | output | 4 | Converter A channel index |
| smp_b | output | 1 | Converter B sample strobe |
| cnv_b | output | 1 | Converter B convert strobe |
| ch_b | output | 4 | Converter B channel index |
| flags | output | 3 | Sticky flags {watchdog, inserted done, regular done} |
| irq | output | 1 | Shared interrupt request |

## Verification
The strobes are sampled at chosen period cycles in both stagger modes. This separates a correct offset and period from wrap errors in the second converter's position and from its start before the first stagger has elapsed.

Preemption is tried at two points:
- mid-conversion in fast mode, with a second trigger during the inserted run. This separates dropping the trigger from queueing it or restarting the run.
- in slow mode, while only B is busy. This shows that the cut-short conversion raises no done flag.

The watchdog is tried with results exactly on both thresholds and with results one step outside. Interrupt masking is tried against a mix of set and clear flags.

// File: rtl/conv_pair_sched.sv
module conv_pair_sched #(
  parameter int CW      = 4,
  parameter int DW      = 12,
  parameter int NI      = 4,
  parameter int CONV    = 14,
  parameter int SMP     = 3,
  parameter int ST_FAST = 7,
  parameter int ST_SLOW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             slow_mode,
  input  logic [CW-1:0]    reg_ch,
  input  logic             ins_trig,
  input  logic [$clog2(NI)-1:0] ins_last,
  input  logic [NI*CW-1:0] ins_ch_a,
  input  logic [NI*CW-1:0] ins_ch_b,
  input  logic [DW-1:0]    ain_a,
  input  logic [DW-1:0]    ain_b,
  input  logic [DW-1:0]    wd_lo,
  input  logic [DW-1:0]    wd_hi,
  input  logic [2:0]       int_en,
  input  logic [2:0]       clr_flag,
  output logic             smp_a,
  output logic             cnv_a,
  output logic [CW-1:0]    ch_a,
  output logic             smp_b,
  output logic             cnv_b,
  output logic [CW-1:0]    ch_b,
  output logic [2:0]       flags,
  output logic             irq
);
  localparam int PW  = $clog2(2 * ST_SLOW);
  localparam int CTW = $clog2(CONV);
  localparam int KW  = $clog2(NI);

  typedef enum logic [1:0] {IDLE, REGR, INSR} st_t;
  st_t st;

  logic [PW-1:0]  ph;
  logic           b_live;
  logic [CTW-1:0] ic;
  logic [KW-1:0]  k;

  wire in_reg = (st == REGR);
  wire in_ins = (st == INSR);

  wire [PW-1:0] stg   = slow_mode ? PW'(ST_SLOW) : PW'(ST_FAST);
  wire [PW-1:0] b_idx = (ph >= stg) ? ph - stg : ph + stg;
  wire          a_on  = in_ins || (in_reg && ph < PW'(CONV));
  wire          b_on  = in_ins || (in_reg && b_live && b_idx < PW'(CONV));
  wire [PW-1:0] a_pos = in_ins ? PW'(ic) : ph;
  wire [PW-1:0] b_pos = in_ins ? PW'(ic) : b_idx;
  wire          done_a = a_on && a_pos == PW'(CONV - 1);
  wire          done_b = b_on && b_pos == PW'(CONV - 1);
  wire          ic_end = (ic == CTW'(CONV - 1));
  wire          ins_end = in_ins && ic_end && k == ins_last;
  wire          eoc_set = in_reg && done_b;
  wire          wd_hit  = (done_a && (ain_a < wd_lo || ain_a > wd_hi)) ||
                          (done_b && (ain_b < wd_lo || ain_b > wd_hi));

  assign smp_a = a_on && a_pos <  PW'(SMP);
  assign cnv_a = a_on && a_pos >= PW'(SMP);
  assign smp_b = b_on && b_pos <  PW'(SMP);
  assign cnv_b = b_on && b_pos >= PW'(SMP);
  assign ch_a  = in_ins ? ins_ch_a[k*CW +: CW] : reg_ch;
  assign ch_b  = in_ins ? ins_ch_b[k*CW +: CW] : reg_ch;
  assign irq   = |(flags & int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      ph     <= '0;
      b_live <= 1'b0;
      ic     <= '0;
      k      <= '0;
    end else if (ins_trig && !in_ins) begin
      st <= INSR;
      ic <= '0;
      k  <= '0;
    end else begin
      case (st)
        IDLE: if (reg_en) begin
          st     <= REGR;
          ph     <= '0;
          b_live <= 1'b0;
        end
        REGR: if (!reg_en) st <= IDLE;
        else begin
          ph <= (ph == 2 * stg - PW'(1)) ? '0 : ph + PW'(1);
          if (ph == stg - PW'(1)) b_live <= 1'b1;
        end
        INSR: if (ic_end) begin
          ic <= '0;
          if (k == ins_last) begin
            st     <= reg_en ? REGR : IDLE;
            ph     <= '0;
            b_live <= 1'b0;
          end else k <= k + KW'(1);
        end else ic <= ic + CTW'(1);
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_flag) | {wd_hit, ins_end, eoc_set};
  end

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_a && cnv_a) && !(smp_b && cnv_b));
  p_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_trig && !in_ins) |=> (in_ins && ic == '0 && k == '0 && smp_a && smp_b));
  p_drop_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ins && ins_trig && !ic_end) |=> (in_ins && ic == $past(ic) + CTW'(1)));
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && reg_en) |=> (in_reg && smp_a && !smp_b && ch_a == reg_ch));
  p_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_set |=> flags[0]);
  p_wd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> flags[2]);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr_flag[0]) |=> flags[0]);
endmodule

// File: tb/conv_pair_sched_tb.sv
module conv_pair_sched_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, reg_en = 0, slow_mode = 0, ins_trig = 0;
  logic [3:0] reg_ch = 4'd5;
  logic [1:0] ins_last = 2'd1;
  logic [15:0] ins_ch_a = {4'd9, 4'd8, 4'd2, 4'd1};
  logic [15:0] ins_ch_b = {4'd11, 4'd10, 4'd7, 4'd6};
  logic [11:0] ain_a = 12'd2000, ain_b = 12'd2000, wd_lo = 12'd100, wd_hi = 12'd3000;
  logic [2:0] int_en = 3'b000, clr_flag = 3'b000;
  logic smp_a, cnv_a, smp_b, cnv_b, irq;
  logic [3:0] ch_a, ch_b;
  logic [2:0] flags;

  conv_pair_sched u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .slow_mode(slow_mode), .reg_ch(reg_ch),
    .ins_trig(ins_trig), .ins_last(ins_last), .ins_ch_a(ins_ch_a), .ins_ch_b(ins_ch_b),
    .ain_a(ain_a), .ain_b(ain_b), .wd_lo(wd_lo), .wd_hi(wd_hi), .int_en(int_en),
    .clr_flag(clr_flag), .smp_a(smp_a), .cnv_a(cnv_a), .ch_a(ch_a), .smp_b(smp_b),
    .cnv_b(cnv_b), .ch_b(ch_b), .flags(flags), .irq(irq));

  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic goto(input int n);
    while (cyc < n) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic start_reg(input logic mode);
    @(negedge clk);
    reg_en = 0; ins_trig = 0; slow_mode = mode; clr_flag = 3'b111;
    repeat (60) @(negedge clk);
    clr_flag = 3'b000; reg_en = 1;
    cyc = -1;
  endtask

  // {slow_mode, cycle, {smp_a, cnv_a, smp_b, cnv_b}}
  localparam logic [12:0] VEC [14] = '{
    {1'b0, 8'd0,  4'b1000}, {1'b0, 8'd3,  4'b0100}, {1'b0, 8'd6,  4'b0100},
    {1'b0, 8'd7,  4'b0110}, {1'b0, 8'd10, 4'b0101}, {1'b0, 8'd14, 4'b1001},
    {1'b0, 8'd21, 4'b0110},
    {1'b1, 8'd0,  4'b1000}, {1'b1, 8'd13, 4'b0100}, {1'b1, 8'd14, 4'b0010},
    {1'b1, 8'd20, 4'b0001}, {1'b1, 8'd27, 4'b0001}, {1'b1, 8'd28, 4'b1000},
    {1'b1, 8'd42, 4'b0010}
  };

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {smp_a, cnv_a, smp_b, cnv_b}, 0);
    chk("R1 flags/irq in reset", {flags, irq}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {smp_a, cnv_a, smp_b, cnv_b, flags, irq}, 0);

    // R2 / R3 table
    for (int i = 0; i < 14; i++) begin
      if (i == 0 || VEC[i][12] != VEC[i-1][12]) start_reg(VEC[i][12]);
      goto(int'(VEC[i][11:4]));
      chk(VEC[i][12] ? "R3 slow strobes" : "R2 fast strobes",
          {smp_a, cnv_a, smp_b, cnv_b}, VEC[i][3:0]);
      if (VEC[i][3]) chk(VEC[i][12] ? "R3 channel" : "R2 channel", ch_a, reg_ch);
    end

    // R7, R9 boundaries, R11, R10 in fast mode
    ain_a = 12'd3000; ain_b = 12'd100;
    start_reg(1'b0);
    goto(20);
    chk("R7 regular flag before B done", flags[0], 0);
    goto(21);
    chk("R7 regular flag after B done", flags[0], 1);
    goto(25);
    chk("R9 no watchdog on thresholds", flags[2], 0);
    ain_b = 12'd99;
    goto(34);
    chk("R9 watchdog before B done", flags[2], 0);
    goto(35);
    chk("R9 watchdog below low", flags[2], 1);
    ain_b = 12'd2000;
    int_en = 3'b010;
    #1 chk("R11 masked irq", irq, 0);
    int_en = 3'b100;
    #1 chk("R11 watchdog irq", irq, 1);
    clr_flag = 3'b100;
    goto(36);
    clr_flag = 3'b000;
    chk("R10 watchdog cleared", flags[2], 0);
    chk("R10 regular flag kept", flags[0], 1);
    chk("R11 irq after clear", irq, 0);
    int_en = 3'b000;

    ain_a = 12'd3001;
    start_reg(1'b0);
    goto(13);
    chk("R9 watchdog before A done", flags[2], 0);
    goto(14);
    chk("R9 watchdog above high", flags[2], 1);
    ain_a = 12'd2000;

    // R4 R5 R6 R8 fast preemption
    start_reg(1'b0);
    goto(9);
    ins_trig = 1;
    goto(10);
    ins_trig = 0;
    chk("R4 A inserted entry 0", {smp_a, ch_a}, {1'b1, 4'd1});
    chk("R4 B inserted entry 0", {smp_b, ch_b}, {1'b1, 4'd6});
    goto(14);
    ins_trig = 1;
    goto(15);
    ins_trig = 0;
    goto(24);
    chk("R5 second entry despite trigger", {smp_a, ch_a, smp_b, ch_b}, {1'b1, 4'd2, 1'b1, 4'd7});
    goto(37);
    chk("R8 inserted flag before end", flags[1], 0);
    goto(38);
    chk("R8 inserted flag after end", flags[1], 1);
    chk("R6 resume A on regular channel", {smp_a, ch_a, smp_b}, {1'b1, reg_ch, 1'b0});
    chk("R5 trigger not queued", {smp_a, ch_a}, {1'b1, reg_ch});
    chk("R6 aborted conversion no regular flag", flags[0], 0);
    goto(45);
    chk("R6 B restarts after stagger", {smp_b, ch_b}, {1'b1, reg_ch});

    // R4 R6 slow preemption
    start_reg(1'b1);
    goto(19);
    ins_trig = 1;
    goto(20);
    ins_trig = 0;
    chk("R4 slow preempt B", {smp_b, ch_b, smp_a, ch_a}, {1'b1, 4'd6, 1'b1, 4'd1});
    goto(48);
    chk("R6 slow resume", {smp_a, ch_a, smp_b}, {1'b1, reg_ch, 1'b0});
    chk("R6 slow aborted no regular flag", flags[1:0], 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule